// File: doc/BRIEF.md
# Interrupt Priority Level Acceptance Gate

This block holds the processor's current interrupt priority level, a 3-bit field kept at bits 8 to 10 of the 16-bit status word. Each cycle it compares a set of request sources against that level and decides whether one of them may be taken. Every source presents a pending flag and a 3-bit level that comes from that source's own control register. The block picks the strongest pending source. That source is taken only at an instruction boundary, and only when its level is strictly above the current level.

When a request is taken, the block emits a one-cycle strobe. In the same cycle it presents the status word as it stood before acceptance, ready for the stack push, and it reports the index of the winning source. The current level then becomes the level of the accepted request, so only a stronger request can interrupt the handler. Nothing sets or clears the level directly. Apart from acceptance, it changes only when the processor reloads the whole status word from a value popped off the stack.

Top module: `irq_lvl_gate`

## Requirements
- R1: After reset, cur_ipl is 0, take is 0, take_src is 0 and push_word is 0.
- R2: A request is taken (take high in the following cycle) only if at_boundary is high and the winning level is strictly greater than cur_ipl. A winner whose level equals cur_ipl is not taken.
- R3: The winner is the pending source with the highest level. Among sources that share that level, the lowest index wins. take_src gives the winner's index while take is high and is 0 otherwise.
- R4: In the cycle where take is high, cur_ipl already shows the accepted level.
- R5: In the cycle where take is high, push_word equals the cpu_word of the boundary cycle with bits 10:8 replaced by the level held before acceptance. push_word is 0 in every other cycle.
- R6: A source programmed with level 0 is never taken, whatever the value of cur_ipl.
- R7: When pop_load is high, cur_ipl takes pop_word[10:8] in the next cycle. The other bits of pop_word have no effect. No request is taken in that cycle.
- R8: Without an acceptance or a pop_load, cur_ipl keeps its value.
- R9: take is high for exactly one cycle per acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| at_boundary | input | 1 | High when the processor sits at an instruction boundary |
| req_pend | input | N_SRC | Pending flag for each source |
| req_lvl | input | 3*N_SRC | Programmed level of each source; source i uses bits 3i+2..3i |
| cpu_word | input | 16 | Live status word from the processor (its bits 10:8 are ignored) |
| pop_load | input | 1 | Reload the status word from a stack pop |
| pop_word | input | 16 | Popped status word |
| cur_ipl | output | 3 | Current interrupt priority level |
| take | output | 1 | One-cycle acceptance strobe |
| take_src | output | clog2(N_SRC) | Index of the accepted source |
| push_word | output | 16 | Status word to push on acceptance |

## Verification
The bench runs four kinds of pattern. In the first, a single source is swept across levels just below, equal to and just above the current level, which separates a strict comparison from a non-strict one. In the second, several sources are raised at once with equal top levels, which exposes the tie order and any mistake in the index that is reported. In the third, requests are presented with at_boundary low and while a pop reload is under way, which shows that the gate conditions and the precedence of the pop are honoured. In the last, long random runs drive nested acceptances followed by pops. Throughout, the current level, the strobe, the index and the push word are compared every cycle against a reference model.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
    parameter int LVL_W   = 3;
    parameter int WORD_W  = 16;
    parameter int IPL_LSB = 8;
    localparam int IPL_MSB = IPL_LSB + LVL_W - 1;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t merge_ipl(input word_t w, input lvl_t l);
        word_t r;
        r = w;
        r[IPL_MSB:IPL_LSB] = l;
        return r;
    endfunction
endpackage

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick
    import irq_lvl_pkg::*;
#(
    parameter int N_SRC = 6,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend,
    input  lvl_t             lvl [N_SRC],
    output logic             win_valid,
    output lvl_t             win_lvl,
    output logic [SRC_W-1:0] win_idx
);
    // Ascending scan: a later source replaces the leader only when its
    // level is strictly higher, so ties keep the lowest index.
    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        win_idx   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (!win_valid || (lvl[i] > win_lvl))) begin
                win_valid = 1'b1;
                win_lvl   = lvl[i];
                win_idx   = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_lvl_state.sv
module irq_lvl_state
    import irq_lvl_pkg::*;
#(
    parameter int N_SRC = 6,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_boundary,
    input  logic             pop_load,
    input  lvl_t             pop_lvl,
    input  word_t            cpu_word,
    input  logic             win_valid,
    input  lvl_t             win_lvl,
    input  logic [SRC_W-1:0] win_idx,
    output lvl_t             ipl,
    output logic             take,
    output logic [SRC_W-1:0] take_src,
    output word_t            push_word
);
    typedef struct packed {
        lvl_t             ipl;
        logic             take;
        logic [SRC_W-1:0] src;
        word_t            push;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.src  = '0;
        st_d.push = '0;
        if (pop_load) begin
            st_d.ipl = pop_lvl;
        end else if (at_boundary && win_valid && (win_lvl > st_q.ipl)) begin
            st_d.take = 1'b1;
            st_d.src  = win_idx;
            st_d.push = merge_ipl(cpu_word, st_q.ipl);
            st_d.ipl  = win_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ipl       = st_q.ipl;
    assign take      = st_q.take;
    assign take_src  = st_q.src;
    assign push_word = st_q.push;

    // R2 / R4 / R5: accepted level lies strictly above the saved level.
    a_r2_strict_raise: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (ipl > push_word[IPL_MSB:IPL_LSB]));
    // R5: saved field equals the level held before the strobe.
    a_r5_saved_level: assert property (@(posedge clk) disable iff (!rst_n)
        (at_boundary && !pop_load) |=> (!take || (push_word[IPL_MSB:IPL_LSB] == $past(ipl))));
    // R2: no strobe follows a cycle off the instruction boundary.
    a_r2_boundary_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !at_boundary |=> !take);
    // R7: reload takes the popped field and blocks acceptance.
    a_r7_pop_reload: assert property (@(posedge clk) disable iff (!rst_n)
        pop_load |=> (!take && (ipl == $past(pop_lvl))));
    // R8: level is stable without boundary or pop.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_boundary && !pop_load) |=> $stable(ipl));
    // R3: idle strobe reports index 0 and an empty push word.
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> ((take_src == '0) && (push_word == '0)));
endmodule

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate
    import irq_lvl_pkg::*;
#(
    parameter int N_SRC = 6,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     at_boundary,
    input  logic [N_SRC-1:0]         req_pend,
    input  logic [N_SRC*LVL_W-1:0]   req_lvl,
    input  logic [WORD_W-1:0]        cpu_word,
    input  logic                     pop_load,
    input  logic [WORD_W-1:0]        pop_word,
    output logic [LVL_W-1:0]         cur_ipl,
    output logic                     take,
    output logic [SRC_W-1:0]         take_src,
    output logic [WORD_W-1:0]        push_word
);
    lvl_t             lvl_arr [N_SRC];
    logic             win_valid;
    lvl_t             win_lvl;
    logic [SRC_W-1:0] win_idx;

    for (genvar g = 0; g < N_SRC; g++) begin : g_split
        assign lvl_arr[g] = req_lvl[g*LVL_W +: LVL_W];
    end

    irq_lvl_pick #(.N_SRC(N_SRC)) u_pick (
        .pend      (req_pend),
        .lvl       (lvl_arr),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .win_idx   (win_idx)
    );

    irq_lvl_state #(.N_SRC(N_SRC)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .at_boundary (at_boundary),
        .pop_load    (pop_load),
        .pop_lvl     (pop_word[IPL_MSB:IPL_LSB]),
        .cpu_word    (cpu_word),
        .win_valid   (win_valid),
        .win_lvl     (win_lvl),
        .win_idx     (win_idx),
        .ipl         (cur_ipl),
        .take        (take),
        .take_src    (take_src),
        .push_word   (push_word)
    );

    // R6: a strobe never reports a level-0 winner.
    a_r6_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cur_ipl != '0));
endmodule

// File: tb/irq_lvl_gate_tb.sv
module irq_lvl_gate_tb;
    localparam int N = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          at_boundary = 1'b0;
    logic [N-1:0]  req_pend = '0;
    logic [N*3-1:0] req_lvl = '0;
    logic [15:0]   cpu_word = '0;
    logic          pop_load = 1'b0;
    logic [15:0]   pop_word = '0;
    logic [2:0]    cur_ipl;
    logic          take;
    logic [SW-1:0] take_src;
    logic [15:0]   push_word;

    int total = 0;
    int bad = 0;
    int m_ipl = 0, m_take = 0, m_src = 0, m_push = 0;

    always #2.5 clk = ~clk;

    irq_lvl_gate #(.N_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary),
        .req_pend(req_pend), .req_lvl(req_lvl), .cpu_word(cpu_word),
        .pop_load(pop_load), .pop_word(pop_word), .cur_ipl(cur_ipl),
        .take(take), .take_src(take_src), .push_word(push_word)
    );

    // Behavioural reference model, updated at every rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ipl = 0; m_take = 0; m_src = 0; m_push = 0;
        end else begin
            int best, bl;
            best = -1; bl = -1;
            for (int i = 0; i < N; i++) begin
                int l;
                l = int'(req_lvl[i*3 +: 3]);
                if (req_pend[i] && l > bl) begin best = i; bl = l; end
            end
            m_take = 0; m_src = 0; m_push = 0;
            if (pop_load) begin
                m_ipl = int'(pop_word[10:8]);
            end else if (at_boundary && best >= 0 && bl > m_ipl) begin
                m_take = 1; m_src = best;
                m_push = (int'(cpu_word) & 'hF8FF) | (m_ipl << 8);
                m_ipl  = bl;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4/R7/R8 cur_ipl", int'(cur_ipl), m_ipl);
        chk("R2/R6/R9 take", int'(take), m_take);
        chk("R3 take_src", int'(take_src), m_src);
        chk("R5 push_word", int'(push_word), m_push);
    endtask

    task automatic set_lvl(input int i, input int l);
        req_lvl[i*3 +: 3] = 3'(l);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ipl", int'(cur_ipl), 0);
        chk("R1 take", int'(take), 0);
        chk("R1 src", int'(take_src), 0);
        chk("R1 push", int'(push_word), 0);
        rst_n = 1'b1;
        step();

        // R6: level-0 source never accepted at ipl 0
        req_pend = 6'b000001; set_lvl(0, 0); at_boundary = 1'b1; cpu_word = 16'h1234;
        step(); step();
        chk("R6 level0 not taken", int'(take), 0);

        // R2: off boundary, no acceptance; R8 level holds
        at_boundary = 1'b0; set_lvl(0, 3);
        step(); step();
        chk("R2 no boundary", int'(take), 0);
        // R2/R4: accept level 3
        at_boundary = 1'b1;
        step();
        chk("R4 ipl after take", int'(cur_ipl), 3);
        chk("R5 push old ipl", int'(push_word), 16'h1034);
        // R9 one-cycle pulse, equal level not retaken (R2)
        step();
        chk("R9 pulse ends", int'(take), 0);
        // R3 tie among sources 2,4 at level 5 and 1 at 4
        req_pend = 6'b010110; set_lvl(1, 4); set_lvl(2, 5); set_lvl(4, 5);
        step();
        chk("R3 tie lowest index", int'(take_src), 2);
        step();
        // R7: pop with simultaneous stronger request
        req_pend = 6'b100000; set_lvl(5, 7);
        pop_load = 1'b1; pop_word = 16'hF9FF;
        step();
        chk("R7 pop value", int'(cur_ipl), 1);
        chk("R7 pop blocks take", int'(take), 0);
        pop_load = 1'b0;
        step();
        chk("R2 stronger accepted", int'(take), 1);

        // Random nested traffic with periodic pops
        for (int c = 0; c < 4000; c++) begin
            at_boundary = ($urandom_range(0, 3) != 0);
            req_pend = N'($urandom);
            req_lvl = (N*3)'({$urandom, $urandom});
            cpu_word = 16'($urandom);
            pop_load = ($urandom_range(0, 5) == 0);
            pop_word = 16'($urandom);
            step();
        end
        pop_load = 1'b0; at_boundary = 1'b0;
        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule